// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses a synchronous DRAM steps through during one read or write burst. A burst is launched with a start column, a burst-length code and an ordering select. From the clock edge that samples the launch, the block presents one column per clock on registered outputs. It also gives a valid flag and a flag that marks the final beat. It is meant to sit beside a controller data path, or inside a behavioural memory model that needs the exact beat-by-beat column order.

A fixed-length burst of 1, 2, 4 or 8 beats stays inside the aligned block of its own size. In sequential order it wraps inside that block. In interleaved order it XORs the beat number into the low column bits. A full-page burst counts upward around the whole 1024-column row and does not stop by itself. A burst-stop input ends any burst early. A new launch during a burst abandons the old sequence and starts the new one at once. This covers, for example, a read that cuts into a write burst.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block leaves that edge with `valid_o` = 0, `last_o` = 0 and `col_o` = 0.
- R2: When `start_i` is high at a clock edge, that edge drives `col_o` to `start_col_i` with `valid_o` = 1. The burst then yields one beat on each following edge.
- R3: `blen_i` is sampled with `start_i`. Codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats, and `valid_o` stays high for exactly that many consecutive cycles. Codes 4 to 7 select full page.
- R4: With `ilv_i` = 0 and a fixed length BL, beat k has column (start & ~(BL-1)) | ((start + k) & (BL-1)).
- R5: With `ilv_i` = 1 and a fixed length BL, beat k has column (start & ~(BL-1)) | ((start ^ k) & (BL-1)).
- R6: In full page, beat k has column (start + k) mod 1024 whatever `ilv_i` is. The burst runs until it is stopped or replaced.
- R7: `last_o` is high only together with `valid_o`, on the final beat of a fixed-length burst. It is never high in full page.
- R8: `stop_i` high at an edge, without `start_i`, makes `valid_o` and `last_o` low from that edge on. While idle it has no effect.
- R9: `start_i` during a burst restarts the sequence from the new column at that edge. If `start_i` and `stop_i` are high together, `start_i` wins.
- R10: After the launch edge, changes on `start_col_i`, `blen_i` and `ilv_i` do not alter the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a burst (read or write issued) |
| start_col_i | input | 10 | Column given with the launch |
| blen_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 4-7: full page) |
| ilv_i | input | 1 | 0 sequential, 1 interleaved order |
| stop_i | input | 1 | Burst stop |
| col_o | output | 10 | Current beat column |
| valid_o | output | 1 | Column is a live beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
A wrong beat counter or a wrongly latched mask shows up as a wrong column on the very next beat. That may be a high bit leaving the aligned block, or a low bit that breaks the step or XOR pattern. A wrong length or a stuck last flag shows up as a burst that is one or more beats too short or too long. Each beat is compared against a queue of expected columns and last flags, and the queue must be empty once the burst is done. Late parameter changes, stops and restarts are applied mid-burst. Any leak of the new inputs into the running burst therefore appears within one cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int unsigned CODE_W = 3;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;
  typedef enum logic [1:0] {ACT_HOLD, ACT_LOAD, ACT_STEP, ACT_IDLE} beat_act_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
  parameter int unsigned COL_W = 10
) (
  input  logic [bcg_pkg::CODE_W-1:0] code_i,
  output logic [COL_W-1:0]           mask_o,
  output logic                       full_o
);
  logic [COL_W-1:0] one_hot;

  always_comb begin
    full_o  = code_i[2];
    one_hot = COL_W'(1) << code_i[1:0];
    mask_o  = full_o ? {COL_W{1'b1}} : (one_hot - COL_W'(1));
  end
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  bcg_pkg::order_e  order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = base_i + beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    logic wrapped;
    assign wrapped = (order_i == bcg_pkg::ORD_ILV) ? (base_i[b] ^ beat_i[b]) : sum[b];
    assign col_o[b] = mask_i[b] ? wrapped : base_i[b];
  end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl (
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  valid_i,
  input  logic                  last_i,
  output bcg_pkg::beat_act_e    act_o
);
  always_comb begin
    if (start_i)                act_o = bcg_pkg::ACT_LOAD;
    else if (stop_i)            act_o = bcg_pkg::ACT_IDLE;
    else if (valid_i && !last_i) act_o = bcg_pkg::ACT_STEP;
    else if (valid_i)           act_o = bcg_pkg::ACT_IDLE;
    else                        act_o = bcg_pkg::ACT_HOLD;
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int unsigned COL_W = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [COL_W-1:0]           start_col_i,
  input  logic [bcg_pkg::CODE_W-1:0] blen_i,
  input  logic                       ilv_i,
  input  logic                       stop_i,
  output logic [COL_W-1:0]           col_o,
  output logic                       valid_o,
  output logic                       last_o
);
  import bcg_pkg::*;

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic [COL_W-1:0] base_q, mask_q, cnt_q, cnt_nxt, calc_col;
  logic             full_q;
  order_e           ord_q;
  beat_act_e        act;

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (blen_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  bcg_beat_ctrl u_ctrl (
    .start_i (start_i),
    .stop_i  (stop_i),
    .valid_i (valid_o),
    .last_i  (last_o),
    .act_o   (act)
  );

  assign cnt_nxt = cnt_q + COL_W'(1);

  bcg_addr_calc #(.COL_W(COL_W)) u_calc (
    .base_i  (base_q),
    .beat_i  (cnt_nxt),
    .mask_i  (mask_q),
    .order_i (ord_q),
    .col_o   (calc_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      ord_q   <= ORD_SEQ;
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      case (act)
        ACT_LOAD: begin
          base_q  <= start_col_i;
          mask_q  <= dec_mask;
          full_q  <= dec_full;
          ord_q   <= (ilv_i && !dec_full) ? ORD_ILV : ORD_SEQ;
          cnt_q   <= '0;
          col_o   <= start_col_i;
          valid_o <= 1'b1;
          last_o  <= !dec_full && (dec_mask == '0);
        end
        ACT_STEP: begin
          cnt_q   <= cnt_nxt;
          col_o   <= calc_col;
          last_o  <= !full_q && (cnt_nxt == mask_q);
        end
        ACT_IDLE: begin
          valid_o <= 1'b0;
          last_o  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R7
  full_never_last_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && full_q) |-> !last_o);

  // R2
  launch_col_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i) |=> (!valid_o && !last_o));

  // R3
  after_last_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !start_i && !stop_i && ord_q == ORD_SEQ) |=>
      (((col_o ^ $past(col_o)) & ~$past(mask_q)) == '0) &&
      ((COL_W'(col_o - $past(col_o)) & $past(mask_q)) == COL_W'(1)));
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [9:0] start_col_i = '0;
  logic [2:0] blen_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [9:0] col_o;
  logic       valid_o;
  logic       last_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3: unexpected beat col=%h last=%b, expected no beat", col_o, last_o);
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({last_o, col_o} !== e) begin
          n_bad++;
          $display("FAIL %s: got last=%b col=%h, expected last=%b col=%h",
                   t, last_o, col_o, e[10], e[9:0]);
        end
      end
    end
  end

  function automatic logic [10:0] model(input logic [9:0] c, input logic [2:0] code,
                                        input logic ilv, input int k);
    logic [9:0] m, kk, col;
    logic full;
    full = code[2];
    m = full ? 10'h3FF : 10'((1 << code[1:0]) - 1);
    kk = 10'(k);
    if (full)     col = c + kk;
    else if (ilv) col = (c & ~m) | ((c ^ kk) & m);
    else          col = (c & ~m) | ((c + kk) & m);
    return {(!full && kk == m), col};
  endfunction

  // Launch at current negedge, push n expected beats, return at next negedge
  // with junk on the parameter inputs (R10).
  task automatic launch(input logic [9:0] c, input logic [2:0] code, input logic ilv,
                        input int n, input string tag);
    start_i = 1'b1; start_col_i = c; blen_i = code; ilv_i = ilv;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model(c, code, ilv, k));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    start_i = 1'b0; start_col_i = ~c; blen_i = code ^ 3'b101; ilv_i = ~ilv;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stop_now;
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    n_chk++;
    if (valid_o !== 1'b0 || last_o !== 1'b0 || exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: idle check valid=%b last=%b pending=%0d, expected 0/0/0",
               tag, valid_o, last_o, exp_q.size());
    end
  endtask

  task automatic natural(input logic [9:0] c, input logic [2:0] code, input logic ilv,
                         input string tag);
    int n;
    n = code[2] ? 1 : (1 << code[1:0]);
    launch(c, code, ilv, n, tag);
    wait_cyc(n + 1);
    check_idle(tag);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    n_chk++;
    if (valid_o !== 1'b0 || last_o !== 1'b0 || col_o !== 10'h000) begin
      n_bad++;
      $display("FAIL R1: valid=%b last=%b col=%h, expected 0 0 000", valid_o, last_o, col_o);
    end
    rst = 1'b0;
    wait_cyc(2);

    natural(10'h005, 3'd0, 1'b0, "R3 R7 BL1");
    natural(10'h3FF, 3'd1, 1'b0, "R4 BL2");
    natural(10'h00D, 3'd2, 1'b0, "R4 BL4 wrap");
    natural(10'h1FB, 3'd3, 1'b0, "R4 BL8 wrap");
    natural(10'h006, 3'd2, 1'b1, "R5 BL4 ilv");
    natural(10'h2A5, 3'd3, 1'b1, "R5 BL8 ilv");
    natural(10'h0C3, 3'd1, 1'b1, "R5 BL2 ilv");

    // R6 full page across the row end, ilv ignored, then stopped (R8)
    launch(10'h3FA, 3'd7, 1'b1, 12, "R6 full wrap");
    wait_cyc(11);
    stop_now();
    wait_cyc(1);
    check_idle("R8 full stop");

    // R6 long full page run through a whole row
    launch(10'h000, 3'd4, 1'b0, 1030, "R6 full long");
    wait_cyc(1029);
    stop_now();
    wait_cyc(1);
    check_idle("R6 full long stop");

    // R8 stop mid fixed burst after 3 beats
    launch(10'h010, 3'd3, 1'b0, 3, "R8 mid stop");
    wait_cyc(2);
    stop_now();
    wait_cyc(2);
    check_idle("R8 mid stop");

    // R8 stop while idle has no effect
    stop_now();
    check_idle("R8 idle stop");

    // R9 restart during a burst
    launch(10'h040, 3'd3, 1'b0, 2, "R9 first");
    wait_cyc(1);
    natural(10'h101, 3'd2, 1'b0, "R9 restart");

    // R9 full page interrupted by a BL2
    launch(10'h200, 3'd7, 1'b0, 5, "R9 full first");
    wait_cyc(4);
    natural(10'h155, 3'd1, 1'b1, "R9 full interrupt");

    // R9 start and stop together: start wins
    stop_i = 1'b1;
    launch(10'h077, 3'd2, 1'b0, 4, "R9 start beats stop");
    stop_i = 1'b0;
    wait_cyc(4);
    check_idle("R9 start beats stop");

    // R10 back-to-back fixed bursts with changing inputs
    natural(10'h3F9, 3'd3, 1'b1, "R10 latched ilv");
    natural(10'h123, 3'd2, 1'b0, "R10 latched seq");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule